// File: doc/BRIEF.md
# Interlaced NTSC sync generator

This block turns a free-running 4x-subcarrier clock (nominally 14.31818 MHz) into the full timing set for an interlaced NTSC raster. Two counters follow the position within a 525-line frame. The frame holds two fields of 262.5 lines each, and the second field begins in the middle of a line. Decode logic derives six timing outputs from these counters: horizontal sync, vertical sync, composite sync with half-line equalizing and broad pulses, blanking, a field flag and a line-alternation flag. A divider supplies a subcarrier square wave at one quarter of the clock.

Horizontal and vertical sync are placed at the counters' zero, a little ahead of the line start that composite sync marks. Frame position zero is the start of vertical sync in the top field. Two restart strobes let a host lock the raster to an outside source: one restarts the current line and the other returns the raster to the top-field origin. A clear input forces the line-alternation flag low. All timing outputs are registered, so every output shows the counter state of the previous clock.

Top module: `ntsc_sync_gen`

## Requirements
- R1: A line lasts LINE_CLKS cycles (910). `hsync_n` is low for the first HSYNC_CLKS cycles of every line (96) and high for the rest.
- R2: A field lasts FRAME_LINES*LINE_CLKS/2 cycles (238875), and a frame holds two fields. The top field starts at frame cycle 0 and the bottom field starts half a line into line (FRAME_LINES-1)/2. `vsync_n` is low for the first 3*EQ_LINES lines of each field (8190 cycles).
- R3: Outside the first 6*EQ_LINES half-lines of a field, `csync_n` goes low CSYNC_LEAD cycles (22) after each line start and stays low for CSYNC_CLKS cycles (68).
- R4: In the first 2*EQ_LINES half-lines of a field, and in half-lines 4*EQ_LINES to 6*EQ_LINES-1, every half-line (LINE_CLKS/2 = 455 cycles, counted from the field start) carries an equalizing pulse. The pulse is low from CSYNC_LEAD for EQ_CLKS cycles (32).
- R5: In half-lines 2*EQ_LINES to 4*EQ_LINES-1 of a field, every half-line carries a broad pulse. The pulse is low from CSYNC_LEAD for LINE_CLKS/2-CSYNC_CLKS cycles (387), which leaves a 68-cycle serration high.
- R6: `blank_n` is low for the first HBLANK_CLKS cycles of every line (154). It is also low for the first VBLANK_LINES*LINE_CLKS+HBLANK_CLKS cycles of each field (18354).
- R7: `field_odd` is high during the top (odd) field and low during the bottom (even) field.
- R8: `line_alt` toggles in the cycle in which `hsync_n` falls. A high `line_alt_clr` forces it low on the next clock and takes priority over every other cause of change.
- R9: `subcarrier` is a square wave with a period of 4 clocks, high for 2 and low for 2. It counts from reset and ignores both restart strobes.
- R10: A high `h_restart` sets the line position to 0 and leaves the frame line unchanged. `hsync_n` falls two clocks after the strobe is sampled.
- R11: A high `v_restart` returns the raster to the top-field origin and sets `line_alt` high. If both strobes are high, `v_restart` wins.
- R12: While `rst` is high, all active-low outputs, `field_odd` and `line_alt` are high and `subcarrier` is low. Starting one clock after `rst` falls, the outputs follow the raster from the origin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4x subcarrier clock |
| rst | input | 1 | Synchronous reset, active high |
| h_restart | input | 1 | Restart the current line at position 0 |
| v_restart | input | 1 | Return the raster to the top-field origin |
| line_alt_clr | input | 1 | Force the line-alternation flag low |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| csync_n | output | 1 | Composite sync with equalizing and broad pulses, active low |
| blank_n | output | 1 | Horizontal and vertical blanking, active low |
| field_odd | output | 1 | High in the top (odd) field |
| line_alt | output | 1 | Line-alternation flag |
| subcarrier | output | 1 | Clock divided by four |

## Verification
A wrong line count shows up within one line as misplaced `hsync_n` and `csync_n` edges. A wrong frame-line count or half-line decode shows up only at a field boundary, as broad pulses out of place, a `vsync_n` shifted by half a line in the bottom field, or a `field_odd` flip at the wrong time. For this reason the bench runs a scaled raster through several frames and both strobes, and compares every output on every clock against a model that works from a flat frame-cycle count. A second instance with the nominal timing then covers the top field's vertical interval, which checks the 910, 8190 and 18354 cycle counts directly.

// File: rtl/ntsc_sync_pkg.sv
package ntsc_sync_pkg;

  // Kind of half-line inside the vertical interval of a field
  typedef enum logic [1:0] {
    SEG_LINE     = 2'd0,
    SEG_EQUALIZE = 2'd1,
    SEG_BROAD    = 2'd2
  } vseg_e;

  // Registered timing outputs, all active low except the field flag
  typedef struct packed {
    logic hsync_n;
    logic vsync_n;
    logic csync_n;
    logic blank_n;
    logic field_odd;
  } sync_vec_t;

  localparam sync_vec_t SYNC_IDLE = '{
    hsync_n:   1'b1,
    vsync_n:   1'b1,
    csync_n:   1'b1,
    blank_n:   1'b1,
    field_odd: 1'b1
  };

endpackage

// File: rtl/ntsc_raster_ctr.sv
module ntsc_raster_ctr #(
  parameter int LINE_CLKS   = 910,
  parameter int FRAME_LINES = 525,
  parameter int HW          = $clog2(LINE_CLKS),
  parameter int LW          = $clog2(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_restart,
  input  logic          v_restart,
  output logic [HW-1:0] hpos,
  output logic [LW-1:0] line,
  output logic          line_start
);

  localparam logic [HW-1:0] H_LAST = HW'(LINE_CLKS - 1);
  localparam logic [LW-1:0] L_LAST = LW'(FRAME_LINES - 1);

  always_ff @(posedge clk) begin
    if (rst || v_restart) begin
      hpos <= '0;
      line <= '0;
    end else if (h_restart) begin
      hpos <= '0;
    end else if (hpos == H_LAST) begin
      hpos <= '0;
      line <= (line == L_LAST) ? '0 : line + 1'b1;
    end else begin
      hpos <= hpos + 1'b1;
    end
  end

  assign line_start = (hpos == '0);

endmodule

// File: rtl/ntsc_field_decode.sv
module ntsc_field_decode #(
  parameter int LINE_CLKS   = 910,
  parameter int FRAME_LINES = 525,
  parameter int HW          = $clog2(LINE_CLKS),
  parameter int LW          = $clog2(FRAME_LINES),
  parameter int QW          = $clog2(2 * FRAME_LINES)
) (
  input  logic [HW-1:0] hpos,
  input  logic [LW-1:0] line,
  output logic          field_odd,
  output logic [QW-1:0] half_idx,
  output logic [HW-1:0] half_pos
);

  localparam int            HALF      = LINE_CLKS / 2;
  localparam logic [HW-1:0] HALF_H    = HW'(HALF);
  localparam logic [QW-1:0] FIELD_HLS = QW'(FRAME_LINES);

  logic          second_half;
  logic [QW-1:0] frame_half;

  always_comb begin
    second_half = (hpos >= HALF_H);
    // twice the line plus the half-line bit gives the frame half-line
    frame_half  = QW'({line, second_half});
    field_odd   = (frame_half < FIELD_HLS);
    half_idx    = field_odd ? frame_half : frame_half - FIELD_HLS;
    half_pos    = second_half ? hpos - HALF_H : hpos;
  end

endmodule

// File: rtl/ntsc_csync_shape.sv
module ntsc_csync_shape
  import ntsc_sync_pkg::*;
#(
  parameter int LINE_CLKS   = 910,
  parameter int FRAME_LINES = 525,
  parameter int CSYNC_LEAD  = 22,
  parameter int CSYNC_CLKS  = 68,
  parameter int EQ_CLKS     = 32,
  parameter int EQ_LINES    = 3,
  parameter int HW          = $clog2(LINE_CLKS),
  parameter int QW          = $clog2(2 * FRAME_LINES)
) (
  input  logic [HW-1:0] hpos,
  input  logic [QW-1:0] half_idx,
  input  logic [HW-1:0] half_pos,
  output logic          csync_lvl
);

  localparam int            HALF      = LINE_CLKS / 2;
  localparam logic [HW-1:0] LEAD      = HW'(CSYNC_LEAD);
  localparam logic [HW-1:0] LINE_END  = HW'(CSYNC_LEAD + CSYNC_CLKS);
  localparam logic [HW-1:0] EQ_END    = HW'(CSYNC_LEAD + EQ_CLKS);
  localparam logic [HW-1:0] BROAD_END = HW'(CSYNC_LEAD + HALF - CSYNC_CLKS);
  localparam logic [QW-1:0] PRE_END   = QW'(2 * EQ_LINES);
  localparam logic [QW-1:0] BROAD_LIM = QW'(4 * EQ_LINES);
  localparam logic [QW-1:0] POST_END  = QW'(6 * EQ_LINES);

  vseg_e seg;

  always_comb begin
    if (half_idx < PRE_END)        seg = SEG_EQUALIZE;
    else if (half_idx < BROAD_LIM) seg = SEG_BROAD;
    else if (half_idx < POST_END)  seg = SEG_EQUALIZE;
    else                           seg = SEG_LINE;
  end

  always_comb begin
    unique case (seg)
      SEG_EQUALIZE: csync_lvl = !((half_pos >= LEAD) && (half_pos < EQ_END));
      SEG_BROAD:    csync_lvl = !((half_pos >= LEAD) && (half_pos < BROAD_END));
      default:      csync_lvl = !((hpos >= LEAD) && (hpos < LINE_END));
    endcase
  end

endmodule

// File: rtl/ntsc_sc_div.sv
module ntsc_sc_div #(
  parameter int DIV_LOG2 = 2
) (
  input  logic clk,
  input  logic rst,
  output logic sc
);

  logic [DIV_LOG2-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign sc = cnt[DIV_LOG2-1];

endmodule

// File: rtl/ntsc_sync_gen.sv
module ntsc_sync_gen
  import ntsc_sync_pkg::*;
#(
  parameter int LINE_CLKS    = 910,
  parameter int FRAME_LINES  = 525,
  parameter int HSYNC_CLKS   = 96,
  parameter int CSYNC_LEAD   = 22,
  parameter int CSYNC_CLKS   = 68,
  parameter int EQ_CLKS      = 32,
  parameter int HBLANK_CLKS  = 154,
  parameter int EQ_LINES     = 3,
  parameter int VBLANK_LINES = 20,
  parameter int SC_DIV_LOG2  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic h_restart,
  input  logic v_restart,
  input  logic line_alt_clr,
  output logic hsync_n,
  output logic vsync_n,
  output logic csync_n,
  output logic blank_n,
  output logic field_odd,
  output logic line_alt,
  output logic subcarrier
);

  localparam int HW = $clog2(LINE_CLKS);
  localparam int LW = $clog2(FRAME_LINES);
  localparam int QW = $clog2(2 * FRAME_LINES);

  localparam logic [HW-1:0] HS_END = HW'(HSYNC_CLKS);
  localparam logic [HW-1:0] HB_END = HW'(HBLANK_CLKS);
  localparam logic [QW-1:0] VS_HL  = QW'(6 * EQ_LINES);
  localparam logic [QW-1:0] VB_HL  = QW'(2 * VBLANK_LINES);

  logic [HW-1:0] hpos;
  logic [LW-1:0] line;
  logic          line_start;
  logic          odd_lvl;
  logic [QW-1:0] half_idx;
  logic [HW-1:0] half_pos;
  logic          csync_lvl;
  sync_vec_t     sync_d, sync_q;
  logic          alt_q;

  ntsc_raster_ctr #(
    .LINE_CLKS(LINE_CLKS), .FRAME_LINES(FRAME_LINES), .HW(HW), .LW(LW)
  ) u_ctr (
    .clk(clk), .rst(rst), .h_restart(h_restart), .v_restart(v_restart),
    .hpos(hpos), .line(line), .line_start(line_start)
  );

  ntsc_field_decode #(
    .LINE_CLKS(LINE_CLKS), .FRAME_LINES(FRAME_LINES), .HW(HW), .LW(LW), .QW(QW)
  ) u_dec (
    .hpos(hpos), .line(line), .field_odd(odd_lvl),
    .half_idx(half_idx), .half_pos(half_pos)
  );

  ntsc_csync_shape #(
    .LINE_CLKS(LINE_CLKS), .FRAME_LINES(FRAME_LINES), .CSYNC_LEAD(CSYNC_LEAD),
    .CSYNC_CLKS(CSYNC_CLKS), .EQ_CLKS(EQ_CLKS), .EQ_LINES(EQ_LINES),
    .HW(HW), .QW(QW)
  ) u_cs (
    .hpos(hpos), .half_idx(half_idx), .half_pos(half_pos), .csync_lvl(csync_lvl)
  );

  ntsc_sc_div #(.DIV_LOG2(SC_DIV_LOG2)) u_sc (
    .clk(clk), .rst(rst), .sc(subcarrier)
  );

  always_comb begin
    sync_d.hsync_n   = !(hpos < HS_END);
    sync_d.vsync_n   = !(half_idx < VS_HL);
    sync_d.csync_n   = csync_lvl;
    // vertical blank ends HBLANK_CLKS into the half-line after VBLANK_LINES lines
    sync_d.blank_n   = !((hpos < HB_END) || (half_idx < VB_HL) ||
                         ((half_idx == VB_HL) && (half_pos < HB_END)));
    sync_d.field_odd = odd_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) sync_q <= SYNC_IDLE;
    else     sync_q <= sync_d;
  end

  always_ff @(posedge clk) begin
    if (rst)               alt_q <= 1'b1;
    else if (line_alt_clr) alt_q <= 1'b0;
    else if (v_restart)    alt_q <= 1'b1;
    else if (line_start)   alt_q <= !alt_q;
  end

  assign hsync_n   = sync_q.hsync_n;
  assign vsync_n   = sync_q.vsync_n;
  assign csync_n   = sync_q.csync_n;
  assign blank_n   = sync_q.blank_n;
  assign field_odd = sync_q.field_odd;
  assign line_alt  = alt_q;

endmodule

// File: rtl/ntsc_sync_gen_chk.sv
module ntsc_sync_gen_chk (
  input logic clk,
  input logic rst,
  input logic line_alt_clr,
  input logic hsync_n,
  input logic vsync_n,
  input logic blank_n,
  input logic field_odd,
  input logic line_alt,
  input logic subcarrier
);

  // R6: horizontal sync always lies inside blanking
  a_r6_hsync_inside_blank: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> !blank_n);

  // R6: vertical sync always lies inside vertical blanking
  a_r6_vsync_inside_blank: assert property (@(posedge clk) disable iff (rst)
    !vsync_n |-> !blank_n);

  // R7: the field flag only changes while vertical sync is active
  a_r7_field_flips_in_vsync: assert property (@(posedge clk) disable iff (rst)
    !$stable(field_odd) |-> !vsync_n);

  // R8: a clear request drives the line flag low on the next clock
  a_r8_clear_forces_low: assert property (@(posedge clk) disable iff (rst)
    line_alt_clr |=> !line_alt);

  // R9: every subcarrier level lasts at least two clocks
  a_r9_subcarrier_half_period: assert property (@(posedge clk) disable iff (rst)
    !$stable(subcarrier) |=> $stable(subcarrier));

endmodule

bind ntsc_sync_gen ntsc_sync_gen_chk u_chk (
  .clk(clk), .rst(rst), .line_alt_clr(line_alt_clr),
  .hsync_n(hsync_n), .vsync_n(vsync_n), .blank_n(blank_n),
  .field_odd(field_odd), .line_alt(line_alt), .subcarrier(subcarrier)
);

// File: tb/sim_ntsc_sync_gen.sv
module sim_ntsc_sync_gen;

  // scaled raster for u0
  localparam int S_L = 40, S_FL = 21, S_HS = 4, S_OFS = 2, S_CW = 3;
  localparam int S_EW = 1, S_HB = 7, S_EQL = 1, S_VBL = 5;
  // nominal raster for u1
  localparam int N_L = 910, N_FL = 525, N_HS = 96, N_OFS = 22, N_CW = 68;
  localparam int N_EW = 32, N_HB = 154, N_EQL = 3, N_VBL = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, hres = 1'b0, vres = 1'b0, lclr = 1'b0, zero = 1'b0;
  logic a_hs, a_vs, a_cs, a_bl, a_fo, a_la, a_sc;
  logic b_hs, b_vs, b_cs, b_bl, b_fo, b_la, b_sc;

  int nchk = 0, nfail = 0;
  bit armed = 0, done = 0;

  ntsc_sync_gen #(
    .LINE_CLKS(S_L), .FRAME_LINES(S_FL), .HSYNC_CLKS(S_HS), .CSYNC_LEAD(S_OFS),
    .CSYNC_CLKS(S_CW), .EQ_CLKS(S_EW), .HBLANK_CLKS(S_HB), .EQ_LINES(S_EQL),
    .VBLANK_LINES(S_VBL), .SC_DIV_LOG2(2)
  ) u0 (
    .clk(clk), .rst(rst), .h_restart(hres), .v_restart(vres), .line_alt_clr(lclr),
    .hsync_n(a_hs), .vsync_n(a_vs), .csync_n(a_cs), .blank_n(a_bl),
    .field_odd(a_fo), .line_alt(a_la), .subcarrier(a_sc)
  );

  ntsc_sync_gen u1 (
    .clk(clk), .rst(rst), .h_restart(zero), .v_restart(zero), .line_alt_clr(zero),
    .hsync_n(b_hs), .vsync_n(b_vs), .csync_n(b_cs), .blank_n(b_bl),
    .field_odd(b_fo), .line_alt(b_la), .subcarrier(b_sc)
  );

  // expected {hsync_n, vsync_n, csync_n, blank_n, field_odd} at frame cycle t
  function automatic logic [4:0] ref_sync(int t, int L, int FL, int HS, int OFS,
                                          int CW, int EW, int HB, int EQL, int VBL);
    int half, fld, ft, h, hk, hp;
    logic top, hs, vs, cs, bl;
    half = L / 2;
    fld  = FL * half;
    h    = t % L;
    top  = (t < fld);
    ft   = top ? t : t - fld;
    hk   = ft / half;
    hp   = ft % half;
    hs   = !(h < HS);
    vs   = !(ft < 3 * EQL * L);
    bl   = !((h < HB) || (ft < VBL * L + HB));
    if (hk < 2 * EQL || (hk >= 4 * EQL && hk < 6 * EQL))
      cs = !(hp >= OFS && hp < OFS + EW);
    else if (hk < 4 * EQL)
      cs = !(hp >= OFS && hp < OFS + half - CW);
    else
      cs = !(h >= OFS && h < OFS + CW);
    return {hs, vs, cs, bl, top};
  endfunction

  // model state
  int   t0 = 0, n0 = 0, t1 = 0, n1 = 0;
  logic lm0 = 1'b1, lm1 = 1'b1;
  logic [4:0] e0 = 5'h1F, e1 = 5'h1F;
  logic el0 = 1'b1, el1 = 1'b1, esc0 = 1'b0, esc1 = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      e0 = 5'h1F; el0 = 1'b1; esc0 = 1'b0; t0 = 0; n0 = 0; lm0 = 1'b1;
      e1 = 5'h1F; el1 = 1'b1; esc1 = 1'b0; t1 = 0; n1 = 0; lm1 = 1'b1;
    end else begin
      e0 = ref_sync(t0, S_L, S_FL, S_HS, S_OFS, S_CW, S_EW, S_HB, S_EQL, S_VBL);
      if (lclr)              lm0 = 1'b0;
      else if (vres)         lm0 = 1'b1;
      else if (t0 % S_L == 0) lm0 = !lm0;
      el0 = lm0;
      n0 = n0 + 1;
      esc0 = ((n0 % 4) >= 2);
      if (vres)      t0 = 0;
      else if (hres) t0 = t0 - (t0 % S_L);
      else           t0 = (t0 + 1) % (S_L * S_FL);

      e1 = ref_sync(t1, N_L, N_FL, N_HS, N_OFS, N_CW, N_EW, N_HB, N_EQL, N_VBL);
      if (t1 % N_L == 0) lm1 = !lm1;
      el1 = lm1;
      n1 = n1 + 1;
      esc1 = ((n1 % 4) >= 2);
      t1 = (t1 + 1) % (N_L * N_FL);
    end
    armed = 1;
  end

  task automatic check(string tag, string sig, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, sig, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (armed && !done) begin
      check(rst ? "R12" : "R1",  "u0.hsync_n",   a_hs, e0[4]);
      check(rst ? "R12" : "R2",  "u0.vsync_n",   a_vs, e0[3]);
      check(rst ? "R12" : "R3,R4,R5", "u0.csync_n", a_cs, e0[2]);
      check(rst ? "R12" : "R6",  "u0.blank_n",   a_bl, e0[1]);
      check(rst ? "R12" : "R7",  "u0.field_odd", a_fo, e0[0]);
      check(rst ? "R12" : "R8",  "u0.line_alt",  a_la, el0);
      check(rst ? "R12" : "R9",  "u0.subcarrier", a_sc, esc0);
      check(rst ? "R12" : "R1",  "u1.hsync_n",   b_hs, e1[4]);
      check(rst ? "R12" : "R2",  "u1.vsync_n",   b_vs, e1[3]);
      check(rst ? "R12" : "R3,R4,R5", "u1.csync_n", b_cs, e1[2]);
      check(rst ? "R12" : "R6",  "u1.blank_n",   b_bl, e1[1]);
      check(rst ? "R12" : "R7",  "u1.field_odd", b_fo, e1[0]);
      check(rst ? "R12" : "R8",  "u1.line_alt",  b_la, el1);
      check(rst ? "R12" : "R9",  "u1.subcarrier", b_sc, esc1);
    end
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    run(3);
    // R12: idle levels while reset is held
    check("R12", "reset idle hsync_n", a_hs, 1'b1);
    check("R12", "reset idle line_alt", a_la, 1'b1);
    check("R12", "reset idle subcarrier", a_sc, 1'b0);
    rst = 1'b0;
    run(1);
    // R12: first cycle after release shows the origin
    check("R12", "origin hsync_n", a_hs, 1'b0);
    check("R12", "origin vsync_n", a_vs, 1'b0);
    check("R7",  "origin field_odd", a_fo, 1'b1);
    check("R8",  "first line line_alt", a_la, 1'b0);
    run(2600);
    // R10: restart mid-line
    run(S_L - (t0 % S_L) + 17);
    hres = 1'b1; run(1); hres = 1'b0;
    check("R10", "hsync_n one clock after restart", a_hs, 1'b1);
    run(1);
    check("R10", "hsync_n two clocks after restart", a_hs, 1'b0);
    run(S_HS);
    check("R10", "hsync_n after pulse", a_hs, 1'b1);
    run(100);
    // R8: clear held for three clocks
    lclr = 1'b1; run(3); lclr = 1'b0;
    check("R8", "line_alt after clear", a_la, 1'b0);
    run(500);
    // R11: vertical restart from the bottom field
    while (t0 < S_L * S_FL / 2 + 30) run(1);
    check("R7", "bottom field flag", a_fo, 1'b0);
    vres = 1'b1; run(1); vres = 1'b0;
    run(1);
    check("R11", "vsync_n at origin", a_vs, 1'b0);
    check("R11", "field_odd at origin", a_fo, 1'b1);
    check("R11", "line_alt at origin", a_la, 1'b0);
    // R11: both strobes together, vertical wins
    run(250);
    hres = 1'b1; vres = 1'b1; run(1); hres = 1'b0; vres = 1'b0;
    run(1);
    check("R11", "vsync_n with both strobes", a_vs, 1'b0);
    run(2000);
    // nominal instance: cover the whole top-field vertical interval
    while (t1 < 20 * N_L + 2000) run(1);
    check("R2", "nominal vsync_n past interval", b_vs, 1'b1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
    end
  end

endmodule